// File: doc/BRIEF.md
# Egress Descriptor Ring Parser

This block walks a circular ring of 128-bit egress descriptors held in memory. Software fills slots and then moves a tail index forward. The parser fetches each slot through a simple read port and checks that the slot's generation bit matches the phase it expects. It then turns the entry into a transfer command for the data mover, a buffer-release request for the buffer stack manager, and a chain request when a chained buffer overflows. Once the last entry of a packet has been handled, it gives a one-cycle notification pulse if that packet asked for one. Payload movement, chain descriptor fetching and checksum arithmetic belong to other blocks.

A single state machine drives the work. Its states are ST_IDLE, ST_FETCH, ST_WAIT, ST_CHECK, ST_CMD, ST_REL, ST_CHAIN and ST_ADV. The transitions are:

- ST_IDLE goes to ST_FETCH when the head differs from the tail.
- ST_FETCH goes to ST_WAIT after one request cycle.
- ST_WAIT goes to ST_CHECK when read data arrives.
- ST_CHECK goes back to ST_IDLE on a phase mismatch, so the same slot is polled again later. Otherwise it goes to the first stage the entry needs, in the order ST_CMD, ST_REL, ST_CHAIN. An entry that needs none of them goes to ST_ADV.
- ST_CMD moves on when the command is accepted. ST_REL moves on when the release is accepted. ST_CHAIN goes to ST_ADV when the chain fetch completes.
- ST_ADV steps the head, updates the notification state and returns to ST_IDLE.

Top module: `egr_ring_parser`

## Requirements
- R1: After reset the head index is 0 and the expected phase is 1. No command, release, chain request, read request or notification is active, and the error flag is 0.
- R2: A slot is read only while the head differs from `tail_idx`. An entry whose generation bit (bit 0) differs from the expected phase produces no output and is re-read until it matches.
- R3: When the head passes the last slot, it returns to 0 and the expected phase inverts. The last slot is 2^`ring_log2`-1. The read address of a slot is `ring_base` + 16 × head.
- R4: A command carries the following fields:
  - the address: bits 105:64 of the entry, sign-extended to 64 bits;
  - the length: bits 29:16, the transfer size;
  - checksum enable: bit 1;
  - checksum start, destination and seed: bits 39:32, 47:40 and 63:48;
  - end-of-packet: bit 4.
  All command fields stay stable while `cmd_valid` is high and `cmd_ready` is low.
- R5: When the no-send flag (bit 2) is set, no command is issued, but the release request is still made.
- R6: A transfer size of zero issues no command, no release and no chain request.
- R7: A release is issued only when the release flag (bit 6) is set and the size is non-zero. It carries the stack index from bits 14:10 and is held until `rel_ready`.
- R8: For a chained entry (bit 5), the first buffer capacity is the size code (bits 9:7) mapped to 128, 256, 512, 1024, 1664, 4096, 10368 or 16384 bytes, minus address bits 6:0. The command length is the smaller of the size and this capacity. Any remainder goes out as a chain request, and no further slot is read until `chain_done`.
- R9: `notif_o` pulses for exactly one cycle when an entry with end-of-packet set completes, provided that entry or any earlier entry of the same packet had the notify flag (bit 3) set.
- R10: `err_o` becomes 1 and stays 1 until reset if a consumed entry has a non-zero reserved bit (15, 31:30 or 127:106). It does the same if the entry has checksum disabled but non-zero checksum fields. The entry is still processed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_base | input | 64 | Byte address of slot 0 |
| ring_log2 | input | 4 | Log2 of ring entries (4 to 12) |
| tail_idx | input | 12 | Software-written tail index |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | 64 | Read address of the head slot |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Entry contents |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Transfer command accepted |
| cmd_addr | output | 64 | Sign-extended start address |
| cmd_len | output | 14 | Bytes to move from the first buffer |
| cmd_csum_en | output | 1 | Checksum enable |
| cmd_csum_start | output | 8 | Checksum start offset |
| cmd_csum_dest | output | 8 | Checksum destination offset |
| cmd_csum_seed | output | 16 | Checksum seed |
| cmd_eop | output | 1 | Command ends a packet |
| rel_valid | output | 1 | Buffer release request |
| rel_ready | input | 1 | Release accepted |
| rel_stack | output | 5 | Stack index to release into |
| chain_req | output | 1 | Chain fetch request, held until done |
| chain_remain | output | 14 | Bytes left for chained buffers |
| chain_done | input | 1 | Chain fetch finished |
| notif_o | output | 1 | Packet notification pulse |
| err_o | output | 1 | Sticky format error |

## Verification
The bench pushes 52 entries through a 16-slot ring across more than three laps. It predicts every command, release, chain remainder and notification from the field rules.

The corner cases it targets, and what a faulty design would show:
- A phase that does not flip on wrap stalls on the second lap.
- A parser that ignores the generation bit consumes a stale slot right after a wrap.
- A wrong capacity table or offset subtraction gives wrong lengths and remainders.
- A parser that treats no-send entries like zero-size ones loses their releases.
- A notify latch cleared at the wrong point drops or adds pulses in multi-entry packets.
- A non-sticky error flag drops back to 0 on the next clean entry.

// File: rtl/egr_ring_pkg.sv
package egr_ring_pkg;

    localparam int DESC_W = 128;
    localparam int VA_W   = 42;
    localparam int LEN_W  = 14;
    localparam int CAP_W  = LEN_W + 1;
    localparam int STK_W  = 5;
    localparam int OFS_W  = 7;

    typedef struct packed {
        logic [21:0]      rsvd_hi;
        logic [VA_W-1:0]  va;
        logic [15:0]      seed;
        logic [7:0]       dst;
        logic [7:0]       start;
        logic [1:0]       rsvd_mid;
        logic [LEN_W-1:0] xfer;
        logic             rsvd_lo;
        logic [STK_W-1:0] stack;
        logic [2:0]       bsize;
        logic             hw_rel;
        logic             chained;
        logic             eop;
        logic             notify;
        logic             no_send;
        logic             csum_en;
        logic             gen;
    } egr_desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_CHECK, ST_CMD, ST_REL, ST_CHAIN, ST_ADV
    } egr_state_t;

    function automatic logic [CAP_W-1:0] bsize_bytes(input logic [2:0] code);
        logic [CAP_W-1:0] r;
        unique case (code)
            3'd0: r = CAP_W'(128);
            3'd1: r = CAP_W'(256);
            3'd2: r = CAP_W'(512);
            3'd3: r = CAP_W'(1024);
            3'd4: r = CAP_W'(1664);
            3'd5: r = CAP_W'(4096);
            3'd6: r = CAP_W'(10368);
            3'd7: r = CAP_W'(16384);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/egr_ring_ptr.sv
module egr_ring_ptr #(
    parameter int IDX_W = 12,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOG_W-1:0] ring_log2,
    input  logic             advance,
    output logic [IDX_W-1:0] head,
    output logic             phase
);
    logic [IDX_W-1:0] last_slot;
    logic             at_last;

    assign last_slot = IDX_W'((32'd1 << ring_log2) - 32'd1);
    assign at_last   = (head == last_slot);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            phase <= 1'b1;
        end else if (advance) begin
            if (at_last) begin
                head  <= '0;
                phase <= ~phase;
            end else begin
                head  <= head + 1'b1;
            end
        end
    end

    p_phase_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance && at_last |=> (phase != $past(phase)) && (head == '0));
    p_phase_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !at_last |=> $stable(phase));

endmodule

// File: rtl/egr_desc_decode.sv
module egr_desc_decode
    import egr_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  egr_desc_t         desc,
    output logic [ADDR_W-1:0] addr_ext,
    output logic [LEN_W-1:0]  first_len,
    output logic [LEN_W-1:0]  spill_len,
    output logic              need_cmd,
    output logic              need_rel,
    output logic              need_chain,
    output logic              fmt_err
);
    localparam int EXT_W = ADDR_W - VA_W;

    logic [CAP_W-1:0] first_cap;
    logic             has_data;
    logic             csum_junk;

    always_comb begin
        addr_ext   = {{EXT_W{desc.va[VA_W-1]}}, desc.va};
        has_data   = (desc.xfer != '0);
        first_cap  = bsize_bytes(desc.bsize) - CAP_W'(desc.va[OFS_W-1:0]);
        need_chain = desc.chained && ({1'b0, desc.xfer} > first_cap);
        first_len  = need_chain ? first_cap[LEN_W-1:0] : desc.xfer;
        spill_len  = desc.xfer - first_len;
        need_cmd   = has_data && !desc.no_send;
        need_rel   = has_data && desc.hw_rel;
        csum_junk  = !desc.csum_en &&
                     ((desc.start != '0) || (desc.dst != '0) || (desc.seed != '0));
        fmt_err    = (desc.rsvd_hi != '0) || (desc.rsvd_mid != '0) ||
                     desc.rsvd_lo || csum_junk;
    end

endmodule

// File: rtl/egr_ring_parser.sv
module egr_ring_parser
    import egr_ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IDX_W  = 12,
    parameter int LOG_W  = $clog2(IDX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [LOG_W-1:0]  ring_log2,
    input  logic [IDX_W-1:0]  tail_idx,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DESC_W-1:0] mem_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_csum_en,
    output logic [7:0]        cmd_csum_start,
    output logic [7:0]        cmd_csum_dest,
    output logic [15:0]       cmd_csum_seed,
    output logic              cmd_eop,
    output logic              rel_valid,
    input  logic              rel_ready,
    output logic [STK_W-1:0]  rel_stack,
    output logic              chain_req,
    output logic [LEN_W-1:0]  chain_remain,
    input  logic              chain_done,
    output logic              notif_o,
    output logic              err_o
);
    localparam int SLOT_SHIFT = $clog2(DESC_W / 8);

    egr_state_t       state_q, state_d;
    egr_desc_t        entry_q;
    logic             notif_pend_q;
    logic             err_q;
    logic [IDX_W-1:0] head;
    logic             phase;
    logic             advance;
    logic             gen_ok;
    logic [ADDR_W-1:0] addr_ext;
    logic [LEN_W-1:0] first_len, spill_len;
    logic             need_cmd, need_rel, need_chain, fmt_err;

    egr_ring_ptr #(.IDX_W(IDX_W), .LOG_W(LOG_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .ring_log2(ring_log2),
        .advance(advance), .head(head), .phase(phase)
    );

    egr_desc_decode #(.ADDR_W(ADDR_W)) dec_i (
        .desc(entry_q), .addr_ext(addr_ext), .first_len(first_len),
        .spill_len(spill_len), .need_cmd(need_cmd), .need_rel(need_rel),
        .need_chain(need_chain), .fmt_err(fmt_err)
    );

    assign gen_ok  = (entry_q.gen == phase);
    assign advance = (state_q == ST_ADV);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // entry capture, packet notify latch, sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q      <= '0;
            notif_pend_q <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            if (state_q == ST_WAIT && mem_rvalid)
                entry_q <= egr_desc_t'(mem_rdata);
            if (state_q == ST_CHECK && gen_ok && fmt_err)
                err_q <= 1'b1;
            if (state_q == ST_ADV)
                notif_pend_q <= entry_q.eop ? 1'b0 : (notif_pend_q | entry_q.notify);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (head != tail_idx) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (mem_rvalid) state_d = ST_CHECK;
            ST_CHECK: begin
                if (!gen_ok)         state_d = ST_IDLE;
                else if (need_cmd)   state_d = ST_CMD;
                else if (need_rel)   state_d = ST_REL;
                else if (need_chain) state_d = ST_CHAIN;
                else                 state_d = ST_ADV;
            end
            ST_CMD: if (cmd_ready) begin
                if (need_rel)        state_d = ST_REL;
                else if (need_chain) state_d = ST_CHAIN;
                else                 state_d = ST_ADV;
            end
            ST_REL: if (rel_ready) state_d = need_chain ? ST_CHAIN : ST_ADV;
            ST_CHAIN: if (chain_done) state_d = ST_ADV;
            ST_ADV:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req        = (state_q == ST_FETCH);
        mem_addr       = ring_base + (ADDR_W'(head) << SLOT_SHIFT);
        cmd_valid      = (state_q == ST_CMD);
        cmd_addr       = addr_ext;
        cmd_len        = first_len;
        cmd_csum_en    = entry_q.csum_en;
        cmd_csum_start = entry_q.start;
        cmd_csum_dest  = entry_q.dst;
        cmd_csum_seed  = entry_q.seed;
        cmd_eop        = entry_q.eop;
        rel_valid      = (state_q == ST_REL);
        rel_stack      = entry_q.stack;
        chain_req      = (state_q == ST_CHAIN);
        chain_remain   = spill_len;
        notif_o        = (state_q == ST_ADV) && entry_q.eop &&
                         (notif_pend_q || entry_q.notify);
        err_o          = err_q;
    end

    p_fetch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && (head == tail_idx) |=> !mem_req);
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
                                    && $stable(cmd_eop));
    p_cmd_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len != '0);
    p_rel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid && !rel_ready |=> rel_valid && $stable(rel_stack));
    p_chain_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chain_req && !chain_done |=> !mem_req && chain_req);
    p_notif_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        notif_o |=> !notif_o);
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: tb/egr_ring_parser_tb_top.sv
module egr_ring_parser_tb_top;
    import egr_ring_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 64;
    localparam int IDX_W  = 12;
    localparam int LOG_W  = 4;
    localparam int RING_N = 16;
    localparam logic [63:0] BASE = 64'h0000_0000_0004_0000;

    logic clk = 1'b0;
    logic rst_n;
    logic [ADDR_W-1:0] ring_base;
    logic [LOG_W-1:0]  ring_log2;
    logic [IDX_W-1:0]  tail_idx;
    logic mem_req, mem_rvalid;
    logic [ADDR_W-1:0] mem_addr;
    logic [DESC_W-1:0] mem_rdata;
    logic cmd_valid, cmd_ready, cmd_csum_en, cmd_eop;
    logic [ADDR_W-1:0] cmd_addr;
    logic [LEN_W-1:0]  cmd_len, chain_remain;
    logic [7:0] cmd_csum_start, cmd_csum_dest;
    logic [15:0] cmd_csum_seed;
    logic rel_valid, rel_ready, chain_req, chain_done, notif_o, err_o;
    logic [STK_W-1:0] rel_stack;

    egr_ring_parser #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LOG_W(LOG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
        .tail_idx(tail_idx), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .cmd_csum_en(cmd_csum_en), .cmd_csum_start(cmd_csum_start),
        .cmd_csum_dest(cmd_csum_dest), .cmd_csum_seed(cmd_csum_seed),
        .cmd_eop(cmd_eop), .rel_valid(rel_valid), .rel_ready(rel_ready),
        .rel_stack(rel_stack), .chain_req(chain_req), .chain_remain(chain_remain),
        .chain_done(chain_done), .notif_o(notif_o), .err_o(err_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [DESC_W-1:0] mem [RING_N];
    int unsigned cyc = 0;
    int n_checks = 0, n_fail = 0, fetches = 0, obs_notif = 0, exp_notif = 0;
    bit exp_pend = 0, exp_err = 0, finished = 0;
    logic [111:0] obs_cmd[$], exp_cmd[$];
    logic [4:0]   obs_rel[$], exp_rel[$];
    logic [13:0]  obs_chain[$], exp_chain[$];

    always @(posedge clk) cyc <= cyc + 1;
    assign cmd_ready = (cyc % 3) != 0;
    assign rel_ready = (cyc % 2) == 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            chain_done <= 1'b0;
        end else begin
            mem_rvalid <= mem_req;
            mem_rdata  <= mem[4'((mem_addr - BASE) >> 4)];
            chain_done <= chain_req && !chain_done;
        end
    end

    always @(negedge clk) if (rst_n) begin
        if (mem_req) fetches++;
        if (cmd_valid && cmd_ready)
            obs_cmd.push_back({cmd_addr, cmd_len, cmd_csum_en, cmd_csum_start,
                               cmd_csum_dest, cmd_csum_seed, cmd_eop});
        if (rel_valid && rel_ready) obs_rel.push_back(rel_stack);
        if (chain_req && chain_done) obs_chain.push_back(chain_remain);
        if (notif_o) obs_notif++;
    end

    task automatic chk(input bit ok, input string req, input string msg);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic int cap_bytes(input logic [2:0] code);
        if (code < 3'd4) return 128 << code;
        else if (code == 3'd4) return 1664;
        else if (code == 3'd5) return 4096;
        else if (code == 3'd6) return 10368;
        else return 16384;
    endfunction

    task automatic write_desc(input int n, input bit gen_ok, input bit bad);
        egr_desc_t d;
        bit lap_even;
        int cap, len;
        bit over;
        logic [63:0] a;
        d = '0;
        lap_even = ((n / 16) % 2) == 0;
        d.gen     = gen_ok ? lap_even : !lap_even;
        d.csum_en = n[0];
        d.start   = d.csum_en ? 8'(n * 3) : 8'd0;
        d.dst     = d.csum_en ? 8'(n + 2) : 8'd0;
        d.seed    = d.csum_en ? 16'(n * 1031) : 16'd0;
        d.no_send = (n % 7) == 3;
        d.notify  = (n % 4) == 1;
        d.eop     = (n % 3) != 1;
        d.chained = (n % 3) == 0;
        d.hw_rel  = ((n % 2) == 1) ^ ((n % 5) == 2);
        d.bsize   = 3'(n % 8);
        d.stack   = 5'(n * 7);
        d.xfer    = ((n % 6) == 4) ? 14'd0 : 14'((n * 1237 + 100) % 16384);
        d.va      = 42'(64'(n) * 64'h0000_0123_4567_89AB);
        d.va[41]  = n[1];
        d.va[6:0] = 7'(n * 13);
        if (bad) d.rsvd_mid = 2'b01;
        mem[n % RING_N] = d;
        if (gen_ok) begin
            a    = {{22{d.va[41]}}, d.va};
            cap  = cap_bytes(d.bsize) - int'(d.va[6:0]);
            over = d.chained && (int'(d.xfer) > cap);
            len  = over ? cap : int'(d.xfer);
            if (!d.no_send && d.xfer != 0)
                exp_cmd.push_back({a, 14'(len), d.csum_en, d.start, d.dst, d.seed, d.eop});
            if (d.hw_rel && d.xfer != 0) exp_rel.push_back(d.stack);
            if (over) exp_chain.push_back(14'(int'(d.xfer) - len));
            if (d.eop) begin
                if (exp_pend || d.notify) exp_notif++;
                exp_pend = 0;
            end else begin
                exp_pend = exp_pend | d.notify;
            end
            if (bad) exp_err = 1;
        end
    endtask

    task automatic compare(input string tag);
        chk(obs_cmd.size() == exp_cmd.size(), "R4/R5/R6/R8",
            $sformatf("%s cmd count actual %0d expected %0d", tag, obs_cmd.size(), exp_cmd.size()));
        for (int i = 0; i < obs_cmd.size() && i < exp_cmd.size(); i++)
            chk(obs_cmd[i] == exp_cmd[i], "R4/R8",
                $sformatf("%s cmd %0d actual %h expected %h", tag, i, obs_cmd[i], exp_cmd[i]));
        chk(obs_rel.size() == exp_rel.size(), "R5/R7",
            $sformatf("%s release count actual %0d expected %0d", tag, obs_rel.size(), exp_rel.size()));
        for (int i = 0; i < obs_rel.size() && i < exp_rel.size(); i++)
            chk(obs_rel[i] == exp_rel[i], "R7",
                $sformatf("%s release %0d actual %0d expected %0d", tag, i, obs_rel[i], exp_rel[i]));
        chk(obs_chain.size() == exp_chain.size(), "R8",
            $sformatf("%s chain count actual %0d expected %0d", tag, obs_chain.size(), exp_chain.size()));
        for (int i = 0; i < obs_chain.size() && i < exp_chain.size(); i++)
            chk(obs_chain[i] == exp_chain[i], "R8",
                $sformatf("%s chain %0d actual %0d expected %0d", tag, i, obs_chain[i], exp_chain[i]));
        chk(obs_notif == exp_notif, "R9",
            $sformatf("%s notify count actual %0d expected %0d", tag, obs_notif, exp_notif));
        chk(err_o == exp_err, "R10",
            $sformatf("%s error flag actual %0b expected %0b", tag, err_o, exp_err));
        obs_cmd.delete(); exp_cmd.delete(); obs_rel.delete(); exp_rel.delete();
        obs_chain.delete(); exp_chain.delete();
        obs_notif = 0; exp_notif = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            chk(1'b0, "watchdog", "run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < RING_N; i++) mem[i] = '0;
        rst_n = 1'b0; ring_base = BASE; ring_log2 = 4'(LOG_W); tail_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(!cmd_valid && !rel_valid && !chain_req, "R1",
            $sformatf("handshakes actual %b%b%b expected 000", cmd_valid, rel_valid, chain_req));
        chk(!mem_req && !notif_o, "R1", $sformatf("req/notif actual %b%b expected 00", mem_req, notif_o));
        chk(err_o == 1'b0, "R1", $sformatf("err actual %b expected 0", err_o));
        chk(mem_addr == BASE, "R1", $sformatf("read addr actual %h expected %h", mem_addr, BASE));
        rst_n = 1'b1;
        // R2 head equals tail: no reads
        repeat (20) @(negedge clk);
        chk(fetches == 0, "R2", $sformatf("reads with empty ring actual %0d expected 0", fetches));
        // R2 wrong generation: polled but not consumed
        write_desc(0, 1'b0, 1'b0);
        tail_idx = 12'd1;
        repeat (40) @(negedge clk);
        chk(fetches > 1, "R2", $sformatf("polling reads actual %0d expected >1", fetches));
        chk(obs_cmd.size() == 0 && obs_rel.size() == 0, "R2",
            $sformatf("outputs on stale slot actual %0d expected 0", obs_cmd.size() + obs_rel.size()));
        write_desc(0, 1'b1, 1'b0);
        repeat (60) @(negedge clk);
        compare("first");
        // R3 sweep across several laps
        for (int b = 0; b < 6; b++) begin
            for (int k = 1; k <= 8; k++) write_desc(b * 8 + k, 1'b1, 1'b0);
            tail_idx = 12'((b * 8 + 9) % RING_N);
            repeat (300) @(negedge clk);
            compare($sformatf("batch%0d", b));
        end
        // R3 stale slot from the previous lap after wrap is not consumed
        tail_idx = 12'd2;
        repeat (40) @(negedge clk);
        chk(obs_cmd.size() == 0 && obs_rel.size() == 0 && obs_chain.size() == 0, "R3",
            $sformatf("old-lap slot outputs actual %0d expected 0", obs_cmd.size() + obs_rel.size()));
        write_desc(49, 1'b1, 1'b0);
        repeat (80) @(negedge clk);
        compare("lap3");
        // R10 reserved bit set: flagged, still consumed, sticky
        write_desc(50, 1'b1, 1'b1);
        tail_idx = 12'd3;
        repeat (80) @(negedge clk);
        compare("bad");
        write_desc(51, 1'b1, 1'b0);
        tail_idx = 12'd4;
        repeat (80) @(negedge clk);
        compare("after_bad");
        chk(err_o == 1'b1, "R10", $sformatf("sticky err actual %b expected 1", err_o));
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule